// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block supervises the start-up and shutdown of a phase-shifted bridge converter using comparator flags that are already digital. It holds a soft-start level in an accumulator. The level climbs by a fixed step on each enable tick during start-up. During a soft stop it falls ten times faster. The level is cleared at once on a hard fault.

The sequencer drives two signals into the PWM generator: a force-low signal and an output enable. It also produces a clamped error command, which cannot exceed the soft-start level in any state except normal running. Faults are handled in two ways:

- **Hard faults:** a supply word below the lockout hysteresis, loss of the reference-good flag, or an external disable. These drop the level to zero and park the sequencer.
- **Overcurrent:** this produces a ramped soft stop. When the level falls below the low threshold, a fresh soft start begins.

A light-load gate with hysteresis on the clamped command can also hold the outputs off.

Top module: `softstart_seq`

## Requirements
- R1: After reset `ss_level` is 0, `force_low` is 1, `out_en` is 0 and `err_clamp` is 0.
- R2: Supply lockout uses a registered hysteresis. It becomes good one cycle after `sup_code` >= 176. It becomes bad one cycle after `sup_code` < 144. Codes from 144 to 175 keep the previous decision. While it is bad, the sequencer stays off with level 0 and `force_low` = 1.
- R3: Any of `ext_dis` = 1, `ref_ok` = 0, or a bad supply decision has two effects. It raises `force_low` in the same cycle. It clears `ss_level` to 0 on the next clock edge. Once the condition is gone, soft start begins from 0.
- R4: During soft start, each cycle with `tick` = 1 adds 8 to `ss_level`, saturating at full scale 1023. A cycle with `tick` = 0 leaves the level unchanged.
- R5: A clock edge that sees `ss_level` = 1023 in soft start moves the sequencer to run. In run, `err_clamp` equals `err_cmd` unclamped.
- R6: `oc_flag` = 1 raises `force_low` in the same cycle and starts a soft stop. In the soft stop, each tick subtracts 80 from the level, saturating at 0, and `force_low` stays 1.
- R7: In soft stop, a clock edge that sees `ss_level` < 102 re-enters soft start with the level kept. The level then climbs by 8 per tick.
- R8: In every state other than run, `err_clamp` = min(`err_cmd`, `ss_level`).
- R9: A registered light-load gate watches `err_clamp`. It closes one cycle after `err_clamp` < 102 and opens one cycle after `err_clamp` >= 124. Values in between hold it.
- R10: `out_en` is 1 only when `force_low` is 0 and the light-load gate is open. `force_low` is 0 only in soft start or run with no fault and no overcurrent present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Ramp enable tick |
| sup_code | input | 8 | Digitised supply voltage |
| ref_ok | input | 1 | Reference-good flag |
| ext_dis | input | 1 | External disable, active high |
| oc_flag | input | 1 | Overcurrent comparator flag |
| err_cmd | input | 10 | Digitised error command |
| ss_level | output | 10 | Soft-start level |
| err_clamp | output | 10 | Error command after clamping |
| force_low | output | 1 | Hold all bridge drives low |
| out_en | output | 1 | Enable the bridge drives |

## Verification
The ramp is tried three ways: with a steady tick, with the tick withheld, and from a non-zero start after a soft stop. Together these separate step size, tick gating and saturation at full scale.

Each of the three hard-fault causes is pulsed during a ramp. An overcurrent is raised in run. The hard-fault cases must clear the level in one edge, while the overcurrent must produce an 80-per-tick descent followed by a restart.

Supply codes and error commands are walked inside and across each hysteresis band. This shows whether the held values in the band are kept or wrongly re-decided.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
  typedef enum logic [2:0] {ST_OFF, ST_HARD, ST_START, ST_RUN, ST_STOP} seq_st_e;
  typedef enum logic [1:0] {LV_HOLD, LV_UP, LV_DOWN, LV_CLEAR} lv_op_e;

  // Saturating signed step of the level between 0 and full.
  function automatic int lvl_step(int cur, int delta, int full);
    int nxt;
    nxt = cur + delta;
    if (nxt < 0) nxt = 0;
    if (nxt > full) nxt = full;
    return nxt;
  endfunction

  function automatic int min_of(int a, int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
  parameter int W         = 8,
  parameter int ON_AT     = 176,
  parameter int OFF_BELOW = 144
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] val,
  output logic         hi
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 hi <= 1'b0;
    else if (val >= W'(ON_AT))  hi <= 1'b1;
    else if (val < W'(OFF_BELOW)) hi <= 1'b0;
  end

  // R2 / R9 hysteresis behaviour
  p_set_r2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    val >= W'(ON_AT) |=> hi);
  p_clr_r2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    val < W'(OFF_BELOW) |=> !hi);
  p_hold_r2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (val >= W'(OFF_BELOW) && val < W'(ON_AT)) |=> $stable(hi));
endmodule

// File: rtl/ss_level.sv
module ss_level
  import ss_seq_pkg::*;
#(
  parameter int LVL_W   = 10,
  parameter int UP_STEP = 8,
  parameter int DN_MULT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  lv_op_e           op,
  output logic [LVL_W-1:0] level
);
  localparam int FULL    = (1 << LVL_W) - 1;
  localparam int DN_STEP = UP_STEP * DN_MULT;

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else begin
      case (op)
        LV_CLEAR: level <= '0;
        LV_UP:    if (tick) level <= LVL_W'(lvl_step(int'(level), UP_STEP, FULL));
        LV_DOWN:  if (tick) level <= LVL_W'(lvl_step(int'(level), -DN_STEP, FULL));
        default:  level <= level;
      endcase
    end
  end

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op == LV_CLEAR |=> level == '0);
  p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == LV_UP && tick && int'(level) <= FULL - UP_STEP)
      |=> int'(level) == int'($past(level)) + UP_STEP);
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && op != LV_CLEAR) |=> $stable(level));
  p_down_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == LV_DOWN && tick && int'(level) >= DN_STEP)
      |=> int'(level) == int'($past(level)) - DN_STEP);
endmodule

// File: rtl/ss_fsm.sv
module ss_fsm
  import ss_seq_pkg::*;
#(
  parameter int LVL_W    = 10,
  parameter int LOW_CODE = 102
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_ok,
  input  logic             ref_ok,
  input  logic             ext_dis,
  input  logic             oc_flag,
  input  logic [LVL_W-1:0] level,
  output seq_st_e          state,
  output lv_op_e           op
);
  localparam logic [LVL_W-1:0] FULL = '1;
  seq_st_e st_d;

  always_comb begin
    st_d = state;
    op   = LV_HOLD;
    if (!uv_ok) begin
      st_d = ST_OFF;  op = LV_CLEAR;
    end else if (!ref_ok || ext_dis) begin
      st_d = ST_HARD; op = LV_CLEAR;
    end else begin
      case (state)
        ST_OFF, ST_HARD: st_d = ST_START;
        ST_START: begin
          if (oc_flag) st_d = ST_STOP;
          else begin
            op = LV_UP;
            if (level == FULL) st_d = ST_RUN;
          end
        end
        ST_RUN:  if (oc_flag) st_d = ST_STOP;
        ST_STOP: begin
          if (level < LVL_W'(LOW_CODE)) st_d = ST_START;
          else op = LV_DOWN;
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= st_d;
  end

  p_uv_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok |=> state == ST_OFF);
  p_run_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(level) == FULL);
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && level < LVL_W'(LOW_CODE) && uv_ok && ref_ok && !ext_dis)
      |=> state == ST_START);
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_seq_pkg::*;
#(
  parameter int SUP_W       = 8,
  parameter int UV_ON_CODE  = 176,
  parameter int UV_OFF_CODE = 144,
  parameter int LVL_W       = 10,
  parameter int UP_STEP     = 8,
  parameter int DN_MULT     = 10,
  parameter int LOW_CODE    = 102,
  parameter int NL_OFF_CODE = 102,
  parameter int NL_ON_CODE  = 124
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SUP_W-1:0] sup_code,
  input  logic             ref_ok,
  input  logic             ext_dis,
  input  logic             oc_flag,
  input  logic [LVL_W-1:0] err_cmd,
  output logic [LVL_W-1:0] ss_level,
  output logic [LVL_W-1:0] err_clamp,
  output logic             force_low,
  output logic             out_en
);
  logic    uv_ok;
  logic    nl_ok;
  logic    hard_fault;
  logic    drive_state;
  seq_st_e state;
  lv_op_e  lv_op;

  hyst_cmp #(.W(SUP_W), .ON_AT(UV_ON_CODE), .OFF_BELOW(UV_OFF_CODE)) u_uvlo (
    .clk(clk), .rst_n(rst_n), .val(sup_code), .hi(uv_ok));

  ss_fsm #(.LVL_W(LVL_W), .LOW_CODE(LOW_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .ref_ok(ref_ok), .ext_dis(ext_dis),
    .oc_flag(oc_flag), .level(ss_level), .state(state), .op(lv_op));

  ss_level #(.LVL_W(LVL_W), .UP_STEP(UP_STEP), .DN_MULT(DN_MULT)) u_lvl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .op(lv_op), .level(ss_level));

  always_comb begin
    if (state == ST_RUN) err_clamp = err_cmd;
    else err_clamp = LVL_W'(min_of(int'(err_cmd), int'(ss_level)));
  end

  hyst_cmp #(.W(LVL_W), .ON_AT(NL_ON_CODE), .OFF_BELOW(NL_OFF_CODE)) u_noload (
    .clk(clk), .rst_n(rst_n), .val(err_clamp), .hi(nl_ok));

  assign hard_fault  = !uv_ok || !ref_ok || ext_dis;
  assign drive_state = (state == ST_START) || (state == ST_RUN);
  assign force_low   = hard_fault || oc_flag || !drive_state;
  assign out_en      = !force_low && nl_ok;

  p_oc_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |-> force_low && !out_en);
  p_dis_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_dis || !ref_ok) |-> force_low);
  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_RUN |-> err_clamp <= ss_level);
  p_en_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (state == ST_START || state == ST_RUN));
endmodule

// File: tb/tb_softstart_seq.sv
`timescale 1ns/1ps
module tb_softstart_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, tick = 1'b1, ref_ok = 1'b1, ext_dis = 1'b0, oc_flag = 1'b0;
  logic [7:0] sup_code = '0;
  logic [9:0] err_cmd = 10'd600;
  logic [9:0] ss_level, err_clamp;
  logic       force_low, out_en;

  // staged stimulus, applied at the falling edge
  logic       s_rst = 0, s_tick = 1, s_ref = 1, s_dis = 0, s_oc = 0;
  int         s_sup = 0, s_err = 600;

  always #2 clk = ~clk;

  softstart_seq dut (.clk(clk), .rst_n(rst_n), .tick(tick), .sup_code(sup_code),
    .ref_ok(ref_ok), .ext_dis(ext_dis), .oc_flag(oc_flag), .err_cmd(err_cmd),
    .ss_level(ss_level), .err_clamp(err_clamp), .force_low(force_low), .out_en(out_en));

  int n_cmp = 0, n_bad = 0;

  typedef struct { string req; int lvl; int clmp; int fl; int en; } exp_t;
  exp_t q[$];

  // Reference model: 0 off, 1 hard, 2 start, 3 run, 4 stop
  int m_st = 0, m_lvl = 0, m_uv = 0, m_nl = 0;

  function automatic int e_clamp();
    if (m_st == 3) return int'(err_cmd);
    return (int'(err_cmd) < m_lvl) ? int'(err_cmd) : m_lvl;
  endfunction
  function automatic int e_fl();
    return (m_uv == 0 || !ref_ok || ext_dis || oc_flag || !(m_st == 2 || m_st == 3)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int e, s;
    if (!rst_n) begin
      m_st = 0; m_lvl = 0; m_uv = 0; m_nl = 0;
    end else begin
      e = e_clamp();
      s = int'(sup_code);
      if (m_uv == 0) begin m_st = 0; m_lvl = 0; end
      else if (!ref_ok || ext_dis) begin m_st = 1; m_lvl = 0; end
      else if (m_st <= 1) m_st = 2;
      else if (m_st == 2) begin
        if (oc_flag) m_st = 4;
        else begin
          if (m_lvl == 1023) m_st = 3;
          if (tick) m_lvl = (m_lvl + 8 > 1023) ? 1023 : m_lvl + 8;
        end
      end else if (m_st == 3) begin
        if (oc_flag) m_st = 4;
      end else begin
        if (m_lvl < 102) m_st = 2;
        else if (tick) m_lvl = (m_lvl < 80) ? 0 : m_lvl - 80;
      end
      if (s >= 176) m_uv = 1; else if (s < 144) m_uv = 0;
      if (e >= 124) m_nl = 1; else if (e < 102) m_nl = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: apply staged inputs, push the expected outputs of this cycle
  task automatic cyc(string req);
    exp_t it;
    @(negedge clk);
    rst_n = s_rst; tick = s_tick; ref_ok = s_ref; ext_dis = s_dis; oc_flag = s_oc;
    sup_code = 8'(s_sup); err_cmd = 10'(s_err);
    #0.5;
    it.req = req; it.lvl = m_lvl; it.clmp = e_clamp(); it.fl = e_fl();
    it.en = (it.fl == 0 && m_nl == 1) ? 1 : 0;
    q.push_back(it);
  endtask

  // Monitor: compare once outputs have settled, before the rising edge
  initial forever begin
    exp_t it;
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      it = q.pop_front();
      chk(it.req, "ss_level",  int'(ss_level),  it.lvl);
      chk(it.req, "err_clamp", int'(err_clamp), it.clmp);
      chk(it.req, "force_low", int'(force_low), it.fl);
      chk(it.req, "out_en",    int'(out_en),    it.en);
    end
  end

  task automatic peek(string req, string what, int exp);
    @(negedge clk); #1.2;
    case (what)
      "ss_level":  chk(req, what, int'(ss_level), exp);
      "err_clamp": chk(req, what, int'(err_clamp), exp);
      "force_low": chk(req, what, int'(force_low), exp);
      default:     chk(req, what, int'(out_en), exp);
    endcase
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) cyc("R1");
    peek("R1", "force_low", 1);
    peek("R1", "ss_level", 0);
    s_rst = 1;
    s_sup = 160; repeat (6) cyc("R2");           // inside band from cold: stays off
    peek("R2", "force_low", 1);
    s_sup = 200; repeat (20) cyc("R4");          // ramp, clamp tracks level
    s_tick = 0;  repeat (5) cyc("R4");           // tick withheld
    s_tick = 1;  repeat (120) cyc("R8");
    repeat (15) cyc("R5");
    peek("R5", "ss_level", 1023);
    s_err = 1000; repeat (3) cyc("R5");
    peek("R5", "err_clamp", 1000);
    s_oc = 1; cyc("R6");
    s_oc = 0; repeat (14) cyc("R6");
    repeat (30) cyc("R7");
    s_err = 600;
    s_dis = 1; repeat (3) cyc("R3");
    peek("R3", "ss_level", 0);
    s_dis = 0; repeat (10) cyc("R3");
    s_ref = 0; repeat (3) cyc("R3");
    s_ref = 1; repeat (140) cyc("R8");
    s_err = 110; repeat (3) cyc("R9");
    s_err = 90;  repeat (3) cyc("R9");
    peek("R9", "out_en", 0);
    s_err = 110; repeat (3) cyc("R9");
    s_err = 130; repeat (3) cyc("R9");
    peek("R9", "out_en", 1);
    s_oc = 1; repeat (2) cyc("R10");
    s_oc = 0; repeat (20) cyc("R10");
    s_sup = 150; repeat (4) cyc("R2");           // band: still on
    s_sup = 140; repeat (4) cyc("R2");
    peek("R2", "ss_level", 0);
    s_sup = 180; repeat (8) cyc("R2");
    repeat (2) @(negedge clk);
    #1.5;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule